// File: doc/BRIEF.md
# Clock Synthesizer Configuration Loader

This block holds the settings of a frequency synthesizer. It stores a 9-bit feedback multiplier, a 2-bit output-divider select and a 3-bit test-mode select. Two load paths write one set of configuration registers. One path is a three-wire serial port: a serial clock, a data line and a load strobe. The other is a parallel bus that carries the multiplier and divider select, with its own load strobe. The parallel path has fixed priority over the serial path.

The serial clock, serial data and both strobes arrive asynchronously. Each one passes through a synchronizer in the system clock domain, and edges are found against the previous synchronized value.

The serial path shifts one bit on each rising serial-clock edge into a fourteen-bit register, most significant bit first. A falling edge of the serial load strobe copies that register into the configuration, but only while the parallel strobe is high. A rising edge of the parallel strobe copies the bus multiplier and divider select into the configuration. The parallel strobe is normally held low from power-up until the system is ready.

The pull-ups that make undriven parallel inputs read as one belong to the pads. They lie outside this block.

Top module: `cfg_loader`

## Requirements
- R1: While rst_n is low at a clock edge, cfg_m, cfg_n and cfg_t become zero and cfg_updated becomes low.
- R2: Each rising edge of ser_clk shifts ser_data into a 14-bit register, most significant bit first. After 14 shifts, the first bit is bit 13 and the last is bit 0. A serial load maps bits 13..11 to cfg_t[2:0], bits 10..9 to cfg_n[1:0] and bits 8..0 to cfg_m[8:0].
- R3: A falling edge of ser_load while par_load is high copies the whole shift register into cfg_t, cfg_n and cfg_m. A load leaves the shift register unchanged, so a second load with no shifting in between gives the same word.
- R4: A falling edge of ser_load while par_load is low changes no output and gives no cfg_updated pulse.
- R5: A rising edge of par_load copies par_m into cfg_m and par_n into cfg_n, and leaves cfg_t unchanged.
- R6: While par_load stays high, changes on par_m and par_n have no effect. A falling edge of par_load also loads nothing.
- R7: When a rising edge of par_load and a falling edge of ser_load are seen in the same cycle, only the parallel load takes effect.
- R8: Every write of the configuration gives a cfg_updated pulse exactly one cycle long. cfg_updated is the only sign that an output has changed.
- R9: With SYNC_STAGES = 2, a strobe edge applied between clock edges shows on the outputs after the third following rising clock edge, and not after the second.
- R10: When more than 14 bits are shifted in before a load, only the last 14 are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_data | input | 1 | Serial data bit, sampled on the rising edge of ser_clk |
| ser_load | input | 1 | Serial load strobe, acts on its falling edge |
| par_load | input | 1 | Parallel load strobe, acts on its rising edge; its high level enables serial loads |
| par_m | input | 9 | Parallel multiplier value |
| par_n | input | 2 | Parallel divider select |
| cfg_m | output | 9 | Stored multiplier |
| cfg_n | output | 2 | Stored divider select |
| cfg_t | output | 3 | Stored test-mode select |
| cfg_updated | output | 1 | One-cycle pulse on each configuration write |

## Verification
The bench uses the default parameters: a 9-bit multiplier, a 2-bit divider select, a 3-bit test select and a two-stage synchronizer. At these widths it can do a fully exhaustive sweep of every parallel multiplier and divider value. It also covers every test and divider value combination over the serial path, together with walking single-bit serial words. The two-stage synchronizer makes the exact latency from strobe edge to output a fixed count of clock edges, so the bench can check it edge by edge. That fixed timing also lets the bench place a parallel rising edge and a serial falling edge in the same cycle on purpose.

// File: rtl/cfg_loader_pkg.sv
// Package: shared widths and the load-source encoding for the loader.
// Assumes the serial word is ordered test select, divider select, multiplier.
package cfg_loader_pkg;
    localparam int unsigned DEF_M_W     = 9;
    localparam int unsigned DEF_N_W     = 2;
    localparam int unsigned DEF_T_W     = 3;
    localparam int unsigned DEF_STAGES  = 2;

    typedef enum logic [1:0] {
        LD_NONE = 2'd0,
        LD_PAR  = 2'd1,
        LD_SER  = 2'd2
    } load_src_e;
endpackage

// File: rtl/cl_sync_bus.sv
// Module: multi-bit synchronizer, one independent flop chain per bit.
// Assumes each bit is a slow level signal, so per-bit skew of one cycle
// is acceptable; the chains reset to zero.
module cl_sync_bus #(
    parameter int unsigned W      = 4,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // Purpose: first capture of the asynchronous inputs.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[0] <= '0;
                else        stg[0] <= din;
            end
        end else begin : g_next
            // Purpose: further settling stage of the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[s] <= '0;
                else        stg[s] <= stg[s-1];
            end
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/cl_edge_det.sv
// Module: per-bit edge detector on synchronized signals.
// POL bit set selects a rising edge, clear selects a falling edge.
// Assumes the inputs are already in the clk domain.
module cl_edge_det #(
    parameter int unsigned W   = 3,
    parameter logic [W-1:0] POL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] hit
);
    logic [W-1:0] prev;

    // Purpose: remember last cycle's level for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (POL[i]) begin : g_rise
            assign hit[i] = lvl[i] & ~prev[i];
        end else begin : g_fall
            assign hit[i] = ~lvl[i] & prev[i];
        end

        // R8: an edge indication never lasts two cycles
        assert_edge_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
            hit[i] |=> !hit[i]);
    end
endmodule

// File: rtl/cl_shifter.sv
// Module: serial configuration shift register, MSB first.
// Assumes shift_en is a one-cycle pulse and din is valid in that cycle.
module cl_shifter #(
    parameter int unsigned W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         din,
    output logic [W-1:0] word
);
    // Purpose: move the word one place up and take the new bit at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[W-2:0], din};
    end

    // R2: a shift takes the sampled bit in at the bottom and keeps the rest
    assert_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word[0] == $past(din)) && (word[W-1:1] == $past(word[W-2:0])));

    // R3: with no shift the word holds, whatever loads happen
    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word));
endmodule

// File: rtl/cl_cfg_latch.sv
// Module: configuration registers with two prioritized write paths.
// A parallel edge wins. A serial edge is accepted only while the
// synchronized parallel strobe is high. Assumes the parallel bus is
// stable around the strobe.
module cl_cfg_latch
    import cfg_loader_pkg::*;
#(
    parameter int unsigned M_W = DEF_M_W,
    parameter int unsigned N_W = DEF_N_W,
    parameter int unsigned T_W = DEF_T_W,
    localparam int unsigned SW = M_W + N_W + T_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           par_hit,
    input  logic           ser_hit,
    input  logic           par_level,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    input  logic [SW-1:0]  shift_word,
    output logic [M_W-1:0] cfg_m,
    output logic [N_W-1:0] cfg_n,
    output logic [T_W-1:0] cfg_t,
    output logic           cfg_updated
);
    load_src_e src;

    // Purpose: pick the write source by fixed priority.
    always_comb begin
        if (par_hit)                     src = LD_PAR;
        else if (ser_hit && par_level)   src = LD_SER;
        else                             src = LD_NONE;
    end

    // Purpose: write the configuration and flag the write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_m       <= '0;
            cfg_n       <= '0;
            cfg_t       <= '0;
            cfg_updated <= 1'b0;
        end else begin
            cfg_updated <= (src != LD_NONE);
            case (src)
                LD_PAR: begin
                    cfg_m <= par_m;
                    cfg_n <= par_n;
                end
                LD_SER: begin
                    cfg_t <= shift_word[SW-1 -: T_W];
                    cfg_n <= shift_word[M_W +: N_W];
                    cfg_m <= shift_word[M_W-1:0];
                end
                default: ;
            endcase
        end
    end

    // R1: reset clears the configuration and the pulse
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (cfg_m == '0) && (cfg_n == '0) && (cfg_t == '0) && !cfg_updated);

    // R5: parallel edge takes the bus and leaves the test select alone
    assert_par_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
        par_hit |=> (cfg_m == $past(par_m)) && (cfg_n == $past(par_n)) && $stable(cfg_t));

    // R3: accepted serial edge copies the full shift word
    assert_ser_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_hit && par_level && !par_hit) |=> ({cfg_t, cfg_n, cfg_m} == $past(shift_word)));

    // R4: serial edge with the parallel strobe low is ignored
    assert_ser_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_hit && !par_level && !par_hit) |=> $stable({cfg_t, cfg_n, cfg_m}) && !cfg_updated);

    // R7: on a collision the serial word does not reach the test select
    assert_priority_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (par_hit && ser_hit) |=> $stable(cfg_t) && (cfg_m == $past(par_m)));

    // R8: the outputs never change without the update pulse
    assert_update_only_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_updated |-> $stable({cfg_t, cfg_n, cfg_m}) || $rose(rst_n));
endmodule

// File: rtl/cfg_loader.sv
// Module: top of the synthesizer configuration loader.
// Synchronizes the serial clock, serial data and both strobes. It detects
// a rising serial clock, a falling serial load and a rising parallel load,
// then drives the shifter and the configuration registers.
// Assumes ser_data is stable around each rising ser_clk for at least
// SYNC_STAGES + 1 system clocks, and the parallel bus likewise around
// par_load.
module cfg_loader
    import cfg_loader_pkg::*;
#(
    parameter int unsigned M_W         = DEF_M_W,
    parameter int unsigned N_W         = DEF_N_W,
    parameter int unsigned T_W         = DEF_T_W,
    parameter int unsigned SYNC_STAGES = DEF_STAGES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ser_clk,
    input  logic           ser_data,
    input  logic           ser_load,
    input  logic           par_load,
    input  logic [M_W-1:0] par_m,
    input  logic [N_W-1:0] par_n,
    output logic [M_W-1:0] cfg_m,
    output logic [N_W-1:0] cfg_n,
    output logic [T_W-1:0] cfg_t,
    output logic           cfg_updated
);
    localparam int unsigned SW = M_W + N_W + T_W;
    // bit 0 serial clock, bit 1 serial load, bit 2 parallel load, bit 3 data
    localparam int unsigned NSYNC = 4;
    localparam int unsigned NEDGE = 3;
    localparam logic [NEDGE-1:0] EDGE_POL = 3'b101;

    logic [NSYNC-1:0] sync_lvl;
    logic [NEDGE-1:0] edge_hit;
    logic [SW-1:0]    shift_word;

    cl_sync_bus #(.W(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_data, par_load, ser_load, ser_clk}),
        .dout  (sync_lvl)
    );

    cl_edge_det #(.W(NEDGE), .POL(EDGE_POL)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl   (sync_lvl[NEDGE-1:0]),
        .hit   (edge_hit)
    );

    cl_shifter #(.W(SW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (edge_hit[0]),
        .din      (sync_lvl[3]),
        .word     (shift_word)
    );

    cl_cfg_latch #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .par_hit     (edge_hit[2]),
        .ser_hit     (edge_hit[1]),
        .par_level   (sync_lvl[2]),
        .par_m       (par_m),
        .par_n       (par_n),
        .shift_word  (shift_word),
        .cfg_m       (cfg_m),
        .cfg_n       (cfg_n),
        .cfg_t       (cfg_t),
        .cfg_updated (cfg_updated)
    );
endmodule

// File: tb/tb_cfg_loader.sv
`timescale 1ns/1ps
module tb_cfg_loader;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ser_clk = 1'b0, ser_data = 1'b0, ser_load = 1'b0, par_load = 1'b0;
    logic [8:0] par_m = '0;
    logic [1:0] par_n = '0;
    logic [8:0] cfg_m;
    logic [1:0] cfg_n;
    logic [2:0] cfg_t;
    logic       cfg_updated;

    int checks = 0, failures = 0, pulses = 0;
    bit done = 1'b0;
    logic [13:0] exp_sr = '0;
    logic [13:0] exp_cfg = '0;

    cfg_loader dut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_data(ser_data),
        .ser_load(ser_load), .par_load(par_load), .par_m(par_m), .par_n(par_n),
        .cfg_m(cfg_m), .cfg_n(cfg_n), .cfg_t(cfg_t), .cfg_updated(cfg_updated)
    );

    always #4 clk = ~clk;

    // count update pulses once per cycle, well after the edge
    always @(posedge clk) begin
        #2;
        if (cfg_updated === 1'b1) pulses++;
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [13:0] cur_cfg();
        return {cfg_t, cfg_n, cfg_m};
    endfunction

    task automatic chk_cfg(input string req, input int p0, input int exp_pulses);
        chk(cur_cfg() === exp_cfg, req, "config", int'(cur_cfg()), int'(exp_cfg));
        chk(pulses - p0 == exp_pulses, req, "pulses", pulses - p0, exp_pulses);
    endtask

    task automatic shift_bit(input logic b);
        ser_data = b; ser_clk = 1'b0;
        step(3);
        ser_clk = 1'b1;
        step(3);
        ser_clk = 1'b0;
        exp_sr = {exp_sr[12:0], b};
    endtask

    task automatic shift_word(input logic [31:0] v, input int nbits);
        for (int i = nbits - 1; i >= 0; i--) shift_bit(v[i]);
    endtask

    task automatic ser_strobe();
        ser_load = 1'b1; step(4);
        ser_load = 1'b0; step(5);
    endtask

    task automatic par_strobe(input logic [8:0] m, input logic [1:0] n);
        par_load = 1'b0; step(4);
        par_m = m; par_n = n; step(1);
        par_load = 1'b1; step(5);
    endtask

    initial begin
        #(8ns * 190000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int p0;
        step(5);
        // R1: reset state
        chk(cur_cfg() === 14'd0, "R1", "config in reset", int'(cur_cfg()), 0);
        chk(cfg_updated === 1'b0, "R1", "pulse in reset", int'(cfg_updated), 0);
        rst_n = 1'b1;
        step(6);
        chk(cur_cfg() === 14'd0, "R1", "config after reset", int'(cur_cfg()), 0);

        // R9: latency of a parallel rising edge through the synchronizer
        par_m = 9'h1A5; par_n = 2'd2; step(1);
        p0 = pulses;
        par_load = 1'b1;
        step(2);
        chk(cur_cfg() === 14'd0, "R9", "not yet after two edges", int'(cur_cfg()), 0);
        chk(cfg_updated === 1'b0, "R9", "no pulse after two edges", int'(cfg_updated), 0);
        step(1);
        exp_cfg = {3'd0, 2'd2, 9'h1A5};
        chk(cur_cfg() === exp_cfg, "R9", "loaded after three edges", int'(cur_cfg()), int'(exp_cfg));
        chk(cfg_updated === 1'b1, "R9", "pulse on third edge", int'(cfg_updated), 1);
        step(1);
        chk(cfg_updated === 1'b0, "R8", "pulse one cycle long", int'(cfg_updated), 0);
        step(3);

        // R5: exhaustive parallel sweep, test select held at its value
        for (int n = 0; n < 4; n++) begin
            for (int m = 0; m < 512; m++) begin
                p0 = pulses;
                par_strobe(m[8:0], n[1:0]);
                exp_cfg = {exp_cfg[13:11], n[1:0], m[8:0]};
                chk_cfg("R5", p0, 1);
            end
        end

        // R6: bus changes while strobe high, then a falling strobe
        p0 = pulses;
        par_m = 9'h0F0; par_n = 2'd1; step(6);
        chk_cfg("R6", p0, 0);
        par_load = 1'b0; step(6);
        chk_cfg("R6", p0, 0);
        par_load = 1'b1; step(6);
        exp_cfg = {exp_cfg[13:11], 2'd1, 9'h0F0};
        chk_cfg("R5", p0, 1);

        // R2/R3/R8: serial sweep over every test and divider value
        for (int t = 0; t < 8; t++) begin
            for (int n = 0; n < 4; n++) begin
                for (int k = 0; k < 4; k++) begin
                    logic [8:0] mv;
                    mv = 9'((k * 137 + t * 29 + n * 7) % 512);
                    if (k == 3) mv = 9'h1FF - mv;
                    shift_word({18'd0, t[2:0], n[1:0], mv}, 14);
                    p0 = pulses;
                    ser_strobe();
                    exp_cfg = exp_sr;
                    chk_cfg("R2", p0, 1);
                end
            end
        end

        // R2: walking single-bit words show the field order
        for (int b = 0; b < 14; b++) begin
            shift_word(32'(1) << b, 14);
            p0 = pulses;
            ser_strobe();
            exp_cfg = 14'(1) << b;
            chk_cfg("R2", p0, 1);
        end

        // R3: a second load without shifting gives the same word
        p0 = pulses;
        ser_strobe();
        chk_cfg("R3", p0, 1);

        // R10: 17 bits shifted, only the last 14 kept
        shift_word(32'h1_6B3D, 17);
        p0 = pulses;
        ser_strobe();
        exp_cfg = 14'h2B3D;
        chk(exp_sr === 14'h2B3D, "R10", "bench model", int'(exp_sr), 'h2B3D);
        chk_cfg("R10", p0, 1);

        // R4: serial load with the parallel strobe low is ignored
        par_m = 9'h055; par_n = 2'd3;
        par_load = 1'b0; step(6);
        shift_word({18'd0, 14'h1C71}, 14);
        p0 = pulses;
        ser_strobe();
        chk_cfg("R4", p0, 0);
        par_load = 1'b1; step(6);
        exp_cfg = {exp_cfg[13:11], 2'd3, 9'h055};
        chk_cfg("R5", p0, 1);
        // R3: the ignored word stayed in the shift register
        p0 = pulses;
        ser_strobe();
        exp_cfg = 14'h1C71;
        chk_cfg("R3", p0, 1);

        // R7: parallel rise and serial fall in the same cycle
        shift_word({18'd0, 14'h2AAA}, 14);
        par_load = 1'b0; ser_load = 1'b1; step(4);
        par_m = 9'h133; par_n = 2'd0; step(1);
        p0 = pulses;
        par_load = 1'b1; ser_load = 1'b0; step(6);
        exp_cfg = {exp_cfg[13:11], 2'd0, 9'h133};
        chk_cfg("R7", p0, 1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule